// File: doc/BRIEF.md
# RC5 Brute-Force Key Search Engine

This block searches for the 64-bit key of an RC5 cipher with 32-bit words, 12 rounds and an 8-byte key, given one known plaintext block and the ciphertext it produces. A host writes a starting key, the plaintext and the expected ciphertext into six 32-bit registers, then pulses `start`. The engine then tries candidate keys one after another with no further help from the host. For each candidate it rebuilds the 26-word expanded-key table, runs the 78 key-mixing steps one per clock, encrypts the plaintext one full round per clock, and compares the result with the expected ciphertext.

A search ends in one of two ways. If a candidate matches, the engine stops, shows the candidate on `match_key` and raises `found`. If the candidate whose low `RANGE_BITS` bits are all ones has been tried without a match, it raises `done` instead. With the default of 32, one start covers at most 2^32 keys. The host polls `busy`, `found` and `done`, reads the result, writes a new starting key and starts again.

Each candidate takes 92 cycles: 1 cycle to set up the table, 78 mixing cycles, 12 round cycles and 1 compare cycle. At 100 MHz this is about 1.09 million keys per second.

Top module: `rc5_key_search`

## Requirements
- R1: After reset, `busy`, `found` and `done` are low and `match_key` is zero.
- R2: The host writes registers with `wr_en`, `wr_addr` and `wr_data`. Address 0 holds key bits 31:0 and address 1 holds key bits 63:32. Key byte n is key bits 8n+7:8n, so the low word is mixing word L0. Addresses 2 and 3 hold the plaintext words A and B. Addresses 4 and 5 hold the expected ciphertext words A and B. Writes made while `busy` is high are ignored.
- R3: A `start` pulse while idle clears `found` and `done`, makes the key register the first candidate, and sets `busy` from the next cycle on. A `start` pulse while `busy` is high has no effect.
- R4: A candidate matches when RC5 encryption of the plaintext under that key gives the expected ciphertext. The encryption uses 32-bit words, 12 rounds, and a 26-word table built from the constants 0xB7E15163 and 0x9E3779B9 with 78 mixing steps. Rotate amounts are the low 5 bits.
- R5: Every candidate takes exactly 92 clock cycles. A search that ends after n candidates keeps `busy` high for 92·n cycles.
- R6: After a candidate that does not match, the next candidate is that key plus one, added to the low `RANGE_BITS` bits.
- R7: On a match the engine goes idle, raises `found` and shows the matching candidate on `match_key`.
- R8: If the candidate whose low `RANGE_BITS` bits are all ones does not match, the engine goes idle with `done` high and `found` low. That last candidate is always tested.
- R9: `found` and `done` are never high together. `found`, `done` and `match_key` keep their values while idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Start a search from the key register |
| busy | output | 1 | Search in progress |
| found | output | 1 | A matching key was found |
| done | output | 1 | Range exhausted without a match |
| match_key | output | 64 | Matching candidate key |

## Verification
A match and the end of the range can happen in the same compare cycle. This is the case when the matching key is the one whose low `RANGE_BITS` bits are all ones. The bench provokes this by starting two keys below the end of a range, with the expected ciphertext taken from that final key. It requires `found` high, `done` low, that key on `match_key`, and `busy` high for exactly three candidates (276 cycles). A second run with no matching key requires the opposite outcome after the same number of cycles.

// File: rtl/rc5_key_search.sv
module rc5_key_search #(
  parameter int ROUNDS     = 12,
  parameter int RANGE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        start,
  output logic        busy,
  output logic        found,
  output logic        done,
  output logic [63:0] match_key
);
  localparam int T  = 2 * ROUNDS + 2;
  localparam int MS = 3 * T;
  localparam int SW = $clog2(T);
  localparam int RW = SW - 1;
  localparam int CW = $clog2(MS);
  localparam logic [31:0] P32 = 32'hB7E15163;
  localparam logic [31:0] Q32 = 32'h9E3779B9;

  typedef enum logic [2:0] {IDLE, INIT, MIX, ENC, CHK} state_t;
  state_t st;

  logic [31:0] key_lo, key_hi, pt_a, pt_b, ct_a, ct_b;
  logic [63:0] cand;
  logic [31:0] s [T];
  logic [31:0] l [2];
  logic [31:0] ra, rb;
  logic [SW-1:0] mi;
  logic          mj;
  logic [CW-1:0] step;
  logic [RW-1:0] rnd;

  function automatic logic [31:0] rotl(input logic [31:0] x, input logic [4:0] n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  logic [31:0] m_a, m_sum, m_b, e_a, e_b;
  assign m_a   = rotl(s[mi] + ra + rb, 5'd3);
  assign m_sum = m_a + rb;
  assign m_b   = rotl(l[mj] + m_sum, m_sum[4:0]);
  assign e_a   = rotl(ra ^ rb, rb[4:0]) + s[{rnd, 1'b0}];
  assign e_b   = rotl(rb ^ e_a, e_a[4:0]) + s[{rnd, 1'b1}];

  assign busy = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_lo <= '0; key_hi <= '0; pt_a <= '0; pt_b <= '0; ct_a <= '0; ct_b <= '0;
    end else if (wr_en && !busy) begin
      case (wr_addr)
        3'd0: key_lo <= wr_data;
        3'd1: key_hi <= wr_data;
        3'd2: pt_a   <= wr_data;
        3'd3: pt_b   <= wr_data;
        3'd4: ct_a   <= wr_data;
        3'd5: ct_b   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; found <= 1'b0; done <= 1'b0; match_key <= '0; cand <= '0;
      ra <= '0; rb <= '0; mi <= '0; mj <= 1'b0; step <= '0; rnd <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          found <= 1'b0;
          done  <= 1'b0;
          cand  <= {key_hi, key_lo};
          st    <= INIT;
        end
        INIT: begin
          for (int k = 0; k < T; k++) s[k] <= P32 + Q32 * 32'(k);
          l[0] <= cand[31:0];
          l[1] <= cand[63:32];
          ra <= '0; rb <= '0; mi <= '0; mj <= 1'b0; step <= '0;
          st <= MIX;
        end
        MIX: begin
          s[mi] <= m_a;
          l[mj] <= m_b;
          mj    <= ~mj;
          mi    <= (mi == SW'(T - 1)) ? '0 : mi + 1'b1;
          step  <= step + 1'b1;
          if (step == CW'(MS - 1)) begin
            ra  <= pt_a + s[0];
            rb  <= pt_b + s[1];
            rnd <= RW'(1);
            st  <= ENC;
          end else begin
            ra <= m_a;
            rb <= m_b;
          end
        end
        ENC: begin
          ra  <= e_a;
          rb  <= e_b;
          rnd <= rnd + 1'b1;
          if (rnd == RW'(ROUNDS)) st <= CHK;
        end
        CHK: begin
          if (ra == ct_a && rb == ct_b) begin
            found     <= 1'b1;
            match_key <= cand;
            st        <= IDLE;
          end else if (&cand[RANGE_BITS-1:0]) begin
            done <= 1'b1;
            st   <= IDLE;
          end else begin
            cand[RANGE_BITS-1:0] <= cand[RANGE_BITS-1:0] + {{(RANGE_BITS-1){1'b0}}, 1'b1};
            st <= INIT;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc5_key_search_chk.sv
module rc5_key_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        found,
  input logic        done,
  input logic [63:0] match_key
);
  a_r9_found_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && done));
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r7_hit_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $fell(busy));
  a_r8_done_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(found) && $stable(done) && $stable(match_key)));
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!found && !done));
endmodule

bind rc5_key_search rc5_key_search_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .found(found), .done(done), .match_key(match_key)
);

// File: tb/rc5_key_search_test.sv
`timescale 1ns/1ps
module rc5_key_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic        busy, found, done;
  logic [63:0] match_key;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  localparam int CPK = 92;

  always #2 clk = ~clk;

  rc5_key_search uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .busy(busy), .found(found), .done(done), .match_key(match_key)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected below 150000", cyc_total);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input logic [4:0] n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction

  function automatic logic [63:0] ref_ct(input logic [63:0] key, input logic [31:0] pa, input logic [31:0] pb);
    logic [31:0] s [26];
    logic [31:0] l [2];
    logic [31:0] a, b;
    int i, j;
    s[0] = 32'hB7E15163;
    for (int k = 1; k < 26; k++) s[k] = s[k-1] + 32'h9E3779B9;
    l[0] = key[31:0];
    l[1] = key[63:32];
    a = 0; b = 0; i = 0; j = 0;
    for (int k = 0; k < 78; k++) begin
      s[i] = rl(s[i] + a + b, 5'd3);
      a = s[i];
      l[j] = rl(l[j] + a + b, 5'(a + b));
      b = l[j];
      i = (i + 1) % 26;
      j = (j + 1) % 2;
    end
    a = pa + s[0];
    b = pb + s[1];
    for (int r = 1; r <= 12; r++) begin
      a = rl(a ^ b, b[4:0]) + s[2*r];
      b = rl(b ^ a, a[4:0]) + s[2*r+1];
    end
    return {b, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [63:0] key, input logic [31:0] pa, input logic [31:0] pb, input logic [63:0] ct);
    wr(3'd0, key[31:0]);
    wr(3'd1, key[63:32]);
    wr(3'd2, pa);
    wr(3'd3, pb);
    wr(3'd4, ct[31:0]);
    wr(3'd5, ct[63:32]);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  localparam logic [63:0] K0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [31:0] PA = 32'h1111_2222;
  localparam logic [31:0] PB = 32'h3333_4444;

  task automatic t_reset();
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 found", 64'(found), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 match_key", match_key, 64'd0);
  endtask

  task automatic t_first_hit();
    int c;
    load(K0, PA, PB, ref_ct(K0, PA, PB));
    run(c);
    check("R4 R7 found on first key", 64'(found), 64'd1);
    check("R7 match_key", match_key, K0);
    check("R9 done low on hit", 64'(done), 64'd0);
    check("R5 one candidate cycles", 64'(c), 64'(CPK));
  endtask

  task automatic t_offset_hit();
    int c;
    load(K0, 32'hDEAD_BEEF, 32'h0BAD_F00D, ref_ct(K0 + 64'd3, 32'hDEAD_BEEF, 32'h0BAD_F00D));
    run(c);
    check("R6 found at key+3", 64'(found), 64'd1);
    check("R6 match_key key+3", match_key, K0 + 64'd3);
    check("R5 four candidate cycles", 64'(c), 64'(4 * CPK));
  endtask

  task automatic t_exhaust();
    int c;
    logic [63:0] k = 64'hA5A5_0F0F_FFFF_FFFD;
    load(k, PA, PB, ref_ct(64'h5555_5555_5555_5555, PA, PB));
    run(c);
    check("R8 done after range end", 64'(done), 64'd1);
    check("R8 found low", 64'(found), 64'd0);
    check("R8 three candidates tested", 64'(c), 64'(3 * CPK));
  endtask

  task automatic t_last_key_hit();
    int c;
    logic [63:0] k = 64'h7777_1234_FFFF_FFFD;
    logic [63:0] last = 64'h7777_1234_FFFF_FFFF;
    load(k, PA, PB, ref_ct(last, PA, PB));
    run(c);
    check("R8 R9 last key hit found", 64'(found), 64'd1);
    check("R9 last key hit done low", 64'(done), 64'd0);
    check("R8 last key match_key", match_key, last);
    check("R5 last key cycles", 64'(c), 64'(3 * CPK));
  endtask

  task automatic t_busy_ignore();
    int c;
    logic [63:0] k = 64'h0F0F_0F0F_1234_5678;
    load(k, PA, PB, ref_ct(k + 64'd1, PA, PB));
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (busy && c < 5000) begin
      c++;
      if (c == 20) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'hFFFF_0000; end
      else if (c == 21) begin wr_addr = 3'd0; wr_data = 32'h0000_0000; end
      else if (c == 22) begin wr_en = 1'b0; start = 1'b1; end
      else if (c == 120) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    wr_en = 1'b0;
    check("R2 writes while busy ignored (found)", 64'(found), 64'd1);
    check("R2 match_key after busy writes", match_key, k + 64'd1);
    check("R3 start while busy no effect on length", 64'(c), 64'(2 * CPK));
    run(c);
    check("R2 key register kept after busy write", match_key, k + 64'd1);
  endtask

  task automatic t_hold_and_clear();
    int c;
    logic [63:0] mk = match_key;
    repeat (50) @(negedge clk);
    check("R9 found held while idle", 64'(found), 64'd1);
    check("R9 match_key held while idle", match_key, mk);
    wr(3'd4, 32'h0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 start clears found", 64'(found), 64'd0);
    check("R3 busy after start", 64'(busy), 64'd1);
    c = 0;
    while (busy && c < 100000) begin c++; @(negedge clk); end
    check("R3 search ended", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_hit();
    t_offset_hit();
    t_exhaust();
    t_last_key_hit();
    t_busy_ignore();
    load(64'h1111_0000_FFFF_FFF0, PA, PB, ref_ct(64'h1111_0000_FFFF_FFF2, PA, PB));
    begin int c; run(c); check("R6 R7 found third candidate", match_key, 64'h1111_0000_FFFF_FFF2); end
    t_hold_and_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule